// File: doc/BRIEF.md
# Multi-Mode Test Observation Register

This block is a bank of flip-flops placed between two clouds of combinational logic. The same flip-flops can serve four purposes. In functional operation they form a plain parallel register. They can be cleared to zero in a single clock. They can form a serial shift chain, so test equipment can load state into the register and read state out of it. They can also run as a multiple-input signature register that folds the parallel inputs into a running compressed value.

If the parallel inputs are held at zero in compaction mode, the register runs as a free linear-feedback pattern generator. It can then drive stimulus into the cloud that follows it. A two-bit mode input selects the role on every clock. The serial output is always the most significant register bit. A signature that has been built up can therefore be shifted out through the scan path and compared off-block.

Top module: `logic_observer_reg`

## Requirements
- R1: When `rst_ni` goes low, `q_o` becomes all zeros at once, without waiting for a clock edge. It stays at zero while the reset is held.
- R2: With `mode_i` = 2'b11 (load), every `q_o[i]` takes `d_i[i]` at the next rising clock edge.
- R3: With `mode_i` = 2'b00 (shift), at each rising edge `q_o[0]` takes `si_i` and `q_o[i]` takes the old `q_o[i-1]` for i ≥ 1. The value of `d_i` has no effect on the result.
- R4: With `mode_i` = 2'b10 (clear), every bit of `q_o` becomes 0 at the next rising edge, whatever `d_i` holds.
- R5: With `mode_i` = 2'b01 (compact), at each rising edge `q_o[0]` takes `d_i[0]` XOR the feedback bit. Each `q_o[i]` for i ≥ 1 takes `d_i[i]` XOR the old `q_o[i-1]`. The feedback bit is the XOR of the register bits selected by `TAP_MASK`, which by default are bit 0 and the top bit.
- R6: In compact mode with `d_i` held at zero, a nonzero state never becomes zero. In the default 3-bit build, starting from 3'b111, the states run 110, 101, 010, 100, 001, 011 and then return to 111 after 7 clocks.
- R7: `so_o` always equals `q_o[WIDTH-1]`.
- R8: A signature compacted from a known input stream can be read from `so_o`, most significant bit first, over `WIDTH` shift cycles. The value read must equal the result computed by applying R5 to that stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Role select: 00 shift, 01 compact, 10 clear, 11 load |
| d_i | input | WIDTH | Parallel data from the upstream logic cloud |
| si_i | input | 1 | Serial input into bit 0 in shift mode |
| q_o | output | WIDTH | Register contents |
| so_o | output | 1 | Serial output, the top register bit |

## Verification
The bench builds the register at its default width of 3 with the default taps on bits 0 and 2. At that size the state space is only 8 values and the parallel input is only 8 values. This makes it possible to check compaction over all 64 combinations of state and input, check load for every input value, and check shift from every starting state. The small width also lets the bench follow the free-running pattern sequence through its whole 7-state cycle. It can then compare a signature built from a 20-word stream with a model that is computed arithmetically in the bench.

// File: rtl/lor_pkg.sv
`timescale 1ns/1ps
package lor_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_MISR  = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;

  typedef struct packed {
    logic shift;
    logic misr;
    logic clear;
    logic load;
  } mode_sel_t;
endpackage

// File: rtl/lor_mode_dec.sv
`timescale 1ns/1ps
module lor_mode_dec
  import lor_pkg::*;
(
  input  logic [1:0] mode_i,
  output mode_sel_t  sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (mode_e'(mode_i))
      MODE_SHIFT: sel_o.shift = 1'b1;
      MODE_MISR:  sel_o.misr  = 1'b1;
      MODE_CLEAR: sel_o.clear = 1'b1;
      MODE_LOAD:  sel_o.load  = 1'b1;
      default:    sel_o = '0;
    endcase
  end
endmodule

// File: rtl/lor_cell.sv
`timescale 1ns/1ps
module lor_cell
  import lor_pkg::*;
(
  input  mode_sel_t sel_i,
  input  logic      d_i,
  input  logic      scan_in_i,
  input  logic      misr_in_i,
  output logic      nxt_o
);
  // clear falls through to zero
  always_comb begin
    nxt_o = 1'b0;
    if (sel_i.shift)     nxt_o = scan_in_i;
    else if (sel_i.misr) nxt_o = d_i ^ misr_in_i;
    else if (sel_i.load) nxt_o = d_i;
  end
endmodule

// File: rtl/logic_observer_reg.sv
`timescale 1ns/1ps
module logic_observer_reg
  import lor_pkg::*;
#(
  parameter int unsigned       WIDTH    = 3,
  parameter logic [WIDTH-1:0]  TAP_MASK = {1'b1, {(WIDTH-2){1'b0}}, 1'b1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             si_i,
  output logic [WIDTH-1:0] q_o,
  output logic             so_o
);
  localparam int unsigned MSB = WIDTH - 1;

  mode_sel_t        sel;
  logic [WIDTH-1:0] q_q, q_d;
  logic             fb;

  lor_mode_dec i_dec (
    .mode_i (mode_i),
    .sel_o  (sel)
  );

  assign fb = ^(q_q & TAP_MASK);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_head
      lor_cell i_cell (
        .sel_i     (sel),
        .d_i       (d_i[0]),
        .scan_in_i (si_i),
        .misr_in_i (fb),
        .nxt_o     (q_d[0])
      );
    end else begin : g_body
      lor_cell i_cell (
        .sel_i     (sel),
        .d_i       (d_i[i]),
        .scan_in_i (q_q[i-1]),
        .misr_in_i (q_q[i-1]),
        .nxt_o     (q_d[i])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o  = q_q;
  assign so_o = q_q[MSB];

  // R2
  normal_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_o == $past(d_i));

  // R3
  scan_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> q_o == {$past(q_o[MSB-1:0]), $past(si_i)});

  // R4
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_o == '0);

  // R5
  misr_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_o[MSB:1] == $past(d_i[MSB:1] ^ q_o[MSB-1:0]));

  // R5
  misr_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_o[0] == $past(d_i[0] ^ (^(q_o & TAP_MASK))));

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && d_i == '0 && q_o != '0) |=> q_o != '0);
endmodule

// File: tb/test_logic_observer_reg.sv
`timescale 1ns/1ps
module test_logic_observer_reg;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] d = '0;
  logic         si = 1'b0;
  logic [W-1:0] q;
  logic         so;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic_observer_reg #(.WIDTH(W)) i_logic_observer_reg (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .d_i    (d),
    .si_i   (si),
    .q_o    (q),
    .so_o   (so)
  );

  function automatic logic [W-1:0] misr_ref(logic [W-1:0] s, logic [W-1:0] din);
    logic [W-1:0] r;
    r[0] = din[0] ^ s[W-1] ^ s[0];
    for (int i = 1; i < W; i++) r[i] = din[i] ^ s[i-1];
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(logic [1:0] m, logic [W-1:0] dv, logic s);
    @(negedge clk);
    mode = m; d = dv; si = s;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] exp;
    logic [W-1:0] sig;
    #12;
    // R1 reset state
    chk("R1 reset q", q, '0);
    chk("R7 reset so", {{(W-1){1'b0}}, so}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R7 load every value
    for (int v = 0; v < (1 << W); v++) begin
      step(2'b11, W'(v), 1'b0);
      chk("R2 load", q, W'(v));
      chk("R7 so msb", {{(W-1){1'b0}}, so}, {{(W-1){1'b0}}, q[W-1]});
    end

    // R3 shift from every state, d ignored
    for (int v = 0; v < (1 << W); v++) begin
      step(2'b11, W'(v), 1'b0);
      exp = W'(v);
      for (int k = 0; k < W + 1; k++) begin
        logic b;
        b = logic'((v + k) & 1);
        step(2'b00, ~exp, b);
        exp = {exp[W-2:0], b};
        chk("R3 shift", q, exp);
      end
    end

    // R4 clear from every state
    for (int v = 0; v < (1 << W); v++) begin
      step(2'b11, W'(v), 1'b0);
      step(2'b10, '1, 1'b1);
      chk("R4 clear", q, '0);
    end

    // R5 compact over all state/input pairs
    for (int v = 0; v < (1 << W); v++) begin
      for (int x = 0; x < (1 << W); x++) begin
        step(2'b11, W'(v), 1'b0);
        step(2'b01, W'(x), 1'b1);
        chk("R5 compact", q, misr_ref(W'(v), W'(x)));
      end
    end

    // R6 free-running sequence
    step(2'b11, 3'b111, 1'b0);
    begin
      logic [W-1:0] seq [7];
      seq = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
      for (int k = 0; k < 7; k++) begin
        step(2'b01, '0, 1'b0);
        chk("R6 lfsr seq", q, seq[k]);
      end
    end

    // R8 compact a stream then scan it out
    step(2'b10, '0, 1'b0);
    exp = '0;
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] dv;
      dv = W'((k * 5 + 3) % 8);
      step(2'b01, dv, 1'b0);
      exp = misr_ref(exp, dv);
    end
    chk("R8 signature held", q, exp);
    sig = '0;
    for (int k = 0; k < W; k++) begin
      sig = {sig[W-2:0], so};
      step(2'b00, '1, 1'b0);
    end
    chk("R8 scanned signature", sig, exp);

    // R1 asynchronous reset between edges
    step(2'b11, 3'b101, 1'b0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear", q, '0);
    @(posedge clk); #1;
    chk("R1 held", q, '0);
    @(negedge clk); rst_n = 1'b1;

    finish_run();
  end
endmodule